// File: doc/BRIEF.md
# Sixteen-Bit Up / Up-Down Timer with Two Compare Channels

This block is a free-running 16-bit counter that advances one step on each cycle in which its timer-clock enable is high. In linear mode it only counts upward and rolls over. In triangle (PWM) mode it climbs to the all-ones value, turns, and descends to zero, then climbs again. Software may load any value into the counter through a preset strobe and data bus. Once loaded, the counter resumes stepping from that value on the next enabled tick.

Two compare channels, A and B, watch the counter continuously. A channel records an event only when a counting step brings the counter onto its compare value. It records nothing when a preset lands on that value, and nothing when the compare value is changed to equal the counter. Each event sets a sticky per-channel flag one cycle after the counter shows the matching value. The flag stays set until software pulses the matching clear bit. The prescaler and any waveform pins live outside this block.

Top module: `dual_compare_timer`

## Requirements
- R1: While `rstN` is low, `count` is 0 and both `irqFlag` bits are 0.
- R2: With `pwmMode` low, each cycle with `tickEn` high and `presetStb` low adds one to `count` at the next clock edge, and 0xFFFF rolls over to 0x0000.
- R3: A cycle with `tickEn` low and `presetStb` low leaves `count` unchanged.
- R4: A cycle with `presetStb` high loads `presetData` into `count` at the next edge, whatever the value of `tickEn`. Later enabled ticks step from the loaded value.
- R5: With `pwmMode` high, the counter steps up to 0xFFFF and then down, giving 0xFFFE, 0xFFFF, 0xFFFE. At the bottom it steps down to 0 and then up, giving 1, 0, 1. Each turning value is held for a single tick.
- R6: Bit 0 of `irqFlag` belongs to channel A (`cmpA`) and bit 1 belongs to channel B (`cmpB`). When an enabled tick moves `count` onto a channel's compare value, that channel's flag is set at the clock edge that follows the cycle in which `count` first shows the value. This is one cycle later than the counter change. The two channels act independently.
- R7: A preset that makes `count` equal to a compare value never sets that channel's flag.
- R8: Changing a compare input so that it equals `count` does not set the flag. This holds even in the cycle in which counting has just brought `count` to that value.
- R9: A flag stays set until a cycle with its `flagClr` bit high, and it reads 0 after the next edge. If a match event for that channel occurs in the same cycle as the clear, the flag stays set.
- R10: While `tickEn` stays low, no new match is detected, even when `count` already equals a compare value.
- R11: When `pwmMode` goes low, the counter steps upward from its current value on the next enabled tick, even if it was descending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer-clock enable; one count step per high cycle |
| pwmMode | input | 1 | 0: linear up count; 1: triangle up/down count |
| presetStb | input | 1 | Load strobe for the counter |
| presetData | input | 16 | Value loaded on a preset |
| cmpA | input | 16 | Compare value of channel A |
| cmpB | input | 16 | Compare value of channel B |
| flagClr | input | 2 | Per-channel flag clear (bit 0 = A, bit 1 = B) |
| count | output | 16 | Current counter value |
| irqFlag | output | 2 | Sticky match flags (bit 0 = A, bit 1 = B) |

## Verification
Suppose the record of whether the last update was a counting step goes wrong. A preset or an idle cycle would then be taken for an arrival. The port would show a spurious flag exactly two cycles after the stimulus, and a vector that presets onto a compare value catches this. A corrupted direction bit shows up on the first tick after a turning point or a mode change, as a step of the wrong sign on `count`. A stale compare history shows up as a flag that rises, or fails to rise, one cycle after a compare input is rewritten.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic load;     // take presetData this edge
    logic advance;  // take one counting step this edge
    logic down;     // direction of that step
  } ctrl_strobes_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import dct_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          pwmMode,
  input  logic          presetStb,
  input  logic          atTop,
  input  logic          atBottom,
  output ctrl_strobes_t strobes
);

  logic dirDownQ;
  logic dirNext;

  // Direction to use for a step taken in this cycle.
  always_comb begin
    dirNext = dirDownQ;
    if (!pwmMode)                  dirNext = 1'b0;
    else if (dirDownQ && atBottom) dirNext = 1'b0;
    else if (!dirDownQ && atTop)   dirNext = 1'b1;
  end

  always_comb begin
    strobes.load    = presetStb;
    strobes.advance = tickEn && !presetStb;
    strobes.down    = dirNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                dirDownQ <= 1'b0;
    else if (!pwmMode)        dirDownQ <= 1'b0;
    else if (strobes.advance) dirDownQ <= dirNext;
  end

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import dct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrl_strobes_t                    strobes,
  input  logic [CNT_W-1:0]                 presetData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     cmpVals,
  input  logic [NUM_CH-1:0]                flagClr,
  output logic [CNT_W-1:0]                 count,
  output logic                             atTop,
  output logic                             atBottom,
  output logic [NUM_CH-1:0]                irqFlag
);

  localparam logic [CNT_W-1:0] TOP_VAL = '1;
  localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic             arrivedQ;  // last update was a counting step

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      arrivedQ <= 1'b0;
    end else begin
      arrivedQ <= strobes.advance;
      if (strobes.load)          cntQ <= presetData;
      else if (strobes.advance)  cntQ <= strobes.down ? cntQ - ONE_VAL : cntQ + ONE_VAL;
    end
  end

  assign count    = cntQ;
  assign atTop    = (cntQ == TOP_VAL);
  assign atBottom = (cntQ == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] cmpPrevQ;
    logic             hit;
    logic             flagQ;

    // Match only when counting arrived here and the compare value held still.
    assign hit = arrivedQ && (cntQ == cmpVals[ch]) && (cmpVals[ch] == cmpPrevQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpPrevQ <= '0;
        flagQ    <= 1'b0;
      end else begin
        cmpPrevQ <= cmpVals[ch];
        if (hit)              flagQ <= 1'b1;
        else if (flagClr[ch]) flagQ <= 1'b0;
      end
    end

    assign irqFlag[ch] = flagQ;
  end

endmodule

// File: rtl/dual_compare_timer.sv
module dual_compare_timer
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             pwmMode,
  input  logic             presetStb,
  input  logic [CNT_W-1:0] presetData,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic [1:0]       flagClr,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       irqFlag
);

  localparam int NUM_CH = 2;

  ctrl_strobes_t                strobes;
  logic                         atTop;
  logic                         atBottom;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpVals;

  assign cmpVals[0] = cmpA;
  assign cmpVals[1] = cmpB;

  timer_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .pwmMode   (pwmMode),
    .presetStb (presetStb),
    .atTop     (atTop),
    .atBottom  (atBottom),
    .strobes   (strobes)
  );

  timer_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .presetData (presetData),
    .cmpVals    (cmpVals),
    .flagClr    (flagClr),
    .count      (count),
    .atTop      (atTop),
    .atBottom   (atBottom),
    .irqFlag    (irqFlag)
  );

endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             pwmMode,
  input logic             presetStb,
  input logic [CNT_W-1:0] presetData,
  input logic [CNT_W-1:0] cmpA,
  input logic [CNT_W-1:0] cmpB,
  input logic [1:0]       flagClr,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       irqFlag
);

  localparam logic [CNT_W-1:0] TOP_VAL = '1;
  localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !presetStb) |=> $stable(count));

  assert_preset_R4: assert property (@(posedge clk) disable iff (!rstN)
    presetStb |=> (count == $past(presetData)));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmMode && tickEn && !presetStb) |=> (count == $past(count) + ONE_VAL));

  assert_turn_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && tickEn && !presetStb && count == TOP_VAL) |=> (count == TOP_VAL - ONE_VAL));

  assert_turn_bottom_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && tickEn && !presetStb && count == '0) |=> (count == ONE_VAL));

  assert_flag_a_at_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag[0]) |-> ($past(count) == $past(cmpA)));

  assert_flag_b_at_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag[1]) |-> ($past(count) == $past(cmpB)));

  assert_flag_a_needs_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag[0]) |-> ($past(tickEn, 2) && !$past(presetStb, 2)));

  assert_flag_b_needs_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag[1]) |-> ($past(tickEn, 2) && !$past(presetStb, 2)));

  assert_clear_a_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagClr[0] |=> (!irqFlag[0] || ($past(count) == $past(cmpA))));

  assert_clear_b_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagClr[1] |=> (!irqFlag[1] || ($past(count) == $past(cmpB))));

endmodule

bind dual_compare_timer timer_checker #(.CNT_W(CNT_W)) i_timer_checker (.*);

// File: tb/test_dual_compare_timer.sv
module test_dual_compare_timer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic        pwmMode;
  logic        presetStb;
  logic [15:0] presetData;
  logic [15:0] cmpA;
  logic [15:0] cmpB;
  logic [1:0]  flagClr;
  logic [15:0] count;
  logic [1:0]  irqFlag;

  int applied = 0;
  int failed  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  dual_compare_timer i_dual_compare_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pwmMode(pwmMode),
    .presetStb(presetStb), .presetData(presetData), .cmpA(cmpA), .cmpB(cmpB),
    .flagClr(flagClr), .count(count), .irqFlag(irqFlag)
  );

  typedef struct packed {
    logic        tick;
    logic        pwm;
    logic        ld;
    logic [15:0] data;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [1:0]  clr;
    logic [15:0] expCnt;
    logic [1:0]  expFlg;
  } vec_t;

  // Flag bit 0 = channel A, bit 1 = channel B. Values hold after the edge.
  localparam vec_t VECS [18] = '{
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd1, 2'b00},      // R2
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd2, 2'b00},      // R2
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd3, 2'b00},      // R6 arrival
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd3, 2'b01},      // R6 flag one later
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd3, 2'b01},      // R9 sticky, R3
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b01, 16'd3, 2'b00},      // R9 clear
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd3, 2'b00},      // R10
    '{1'b0, 1'b0, 1'b1, 16'd5,    16'd3, 16'd5, 2'b00, 16'd5, 2'b00},      // R4
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd5, 2'b00},      // R7
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd3, 16'd5, 2'b00, 16'd6, 2'b00},      // R4 resume
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd6, 16'd5, 2'b00, 16'd6, 2'b00},      // R8
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd6, 16'd5, 2'b00, 16'd6, 2'b00},      // R8
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd7, 16'd7, 2'b00, 16'd7, 2'b00},      // R6
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd7, 16'd7, 2'b00, 16'd8, 2'b11},      // R6 both
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'd7, 16'd7, 2'b11, 16'd8, 2'b00},      // R9
    '{1'b1, 1'b0, 1'b1, 16'hFFFE, 16'd7, 16'd7, 2'b00, 16'hFFFE, 2'b00},   // R4 priority
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd7, 16'd7, 2'b00, 16'hFFFF, 2'b00},   // R2
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'd7, 16'd7, 2'b00, 16'h0000, 2'b00}    // R2 wrap
  };

  task automatic step(input logic t, input logic p, input logic l, input logic [15:0] d,
                      input logic [15:0] a, input logic [15:0] b, input logic [1:0] c);
    tickEn = t; pwmMode = p; presetStb = l; presetData = d;
    cmpA = a; cmpB = b; flagClr = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] expC, input logic [1:0] expF);
    applied++;
    if (count !== expC || irqFlag !== expF) begin
      failed++;
      $display("FAIL %s: count=%h flags=%b expected count=%h flags=%b",
               req, count, irqFlag, expC, expF);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    applied++;
    failed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    tickEn = 1'b1; pwmMode = 1'b0; presetStb = 1'b0; presetData = '0;
    cmpA = 16'd3; cmpB = 16'd5; flagClr = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 16'h0000, 2'b00);
    rstN = 1'b1;

    for (int i = 0; i < 18; i++) begin
      step(VECS[i].tick, VECS[i].pwm, VECS[i].ld, VECS[i].data,
           VECS[i].ca, VECS[i].cb, VECS[i].clr);
      check($sformatf("R2-table vector %0d", i), VECS[i].expCnt, VECS[i].expFlg);
    end

    // R5: triangle turnaround at the top
    step(1'b0, 1'b1, 1'b1, 16'hFFFD, 16'd100, 16'd100, 2'b00);
    check("R5 preset", 16'hFFFD, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5", 16'hFFFE, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5 top", 16'hFFFF, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5 turn down", 16'hFFFE, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5 descending", 16'hFFFD, 2'b00);
    // R5: bottom turnaround, direction kept across the preset
    step(1'b0, 1'b1, 1'b1, 16'd2, 16'd100, 16'd100, 2'b00);
    check("R5 preset low", 16'd2, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5", 16'd1, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5 bottom", 16'd0, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5 turn up", 16'd1, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R5 ascending", 16'd2, 2'b00);
    // R11: leave triangle mode while descending
    step(1'b1, 1'b1, 1'b1, 16'd50, 16'd100, 16'd100, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R11 setup", 16'd51, 2'b00);
    step(1'b0, 1'b1, 1'b1, 16'hFFFF, 16'd100, 16'd100, 2'b00);
    step(1'b1, 1'b1, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R11 descending", 16'hFFFE, 2'b00);
    step(1'b1, 1'b0, 1'b0, 16'h0, 16'd100, 16'd100, 2'b00);
    check("R11 up again", 16'hFFFF, 2'b00);

    // R9: event and clear in the same cycle, event wins
    step(1'b0, 1'b0, 1'b1, 16'd98, 16'd99, 16'd200, 2'b00);
    step(1'b1, 1'b0, 1'b0, 16'h0, 16'd99, 16'd200, 2'b00);
    check("R6 arrival", 16'd99, 2'b00);
    step(1'b0, 1'b0, 1'b0, 16'h0, 16'd99, 16'd200, 2'b00);
    check("R6 channel A only", 16'd99, 2'b01);
    step(1'b1, 1'b0, 1'b1, 16'd98, 16'd99, 16'd200, 2'b00);
    step(1'b1, 1'b0, 1'b0, 16'h0, 16'd99, 16'd200, 2'b00);
    check("R9 rearrive", 16'd99, 2'b01);
    step(1'b0, 1'b0, 1'b0, 16'h0, 16'd99, 16'd200, 2'b01);
    check("R9 event beats clear", 16'd99, 2'b01);
    step(1'b0, 1'b0, 1'b0, 16'h0, 16'd99, 16'd200, 2'b01);
    check("R9 clear", 16'd99, 2'b00);

    // R8: compare moved in the very cycle counting lands on it
    step(1'b1, 1'b0, 1'b0, 16'h0, 16'd99, 16'd200, 2'b00);
    check("R8 setup", 16'd100, 2'b00);
    step(1'b0, 1'b0, 1'b0, 16'h0, 16'd99, 16'd100, 2'b00);
    check("R8 moved compare", 16'd100, 2'b00);

    // R1: reset in mid run
    step(1'b1, 1'b0, 1'b0, 16'h0, 16'd101, 16'd101, 2'b00);
    rstN = 1'b0;
    step(1'b1, 1'b0, 1'b0, 16'h0, 16'd101, 16'd101, 2'b00);
    check("R1 mid-run reset", 16'h0000, 2'b00);

    finishRun();
  end

endmodule